// File: doc/BRIEF.md
# Glitch-Free Differential Clock Stop Gate

This block sits between a running reference clock and a differential clock output pair. The pair has a true leg and a complement leg, and each leg has its own output-enable that stands in for a three-state driver. A power-down pin, active low and asynchronous to everything, asks the gate to stop the pair. The gate brings the pin into the clock domain through a flop chain. It accepts a change of the pin only after two consecutive rising-edge samples agree. It then stops or restarts the pair only at a falling edge of the reference clock, so no clock phase is ever cut short.

The complement leg carries the reference clock and the true leg carries its inverse. A stop therefore lands when the complement falls and the true leg rises, and both legs freeze there. A drive-mode bit chooses how the stopped pair is parked. With the bit clear, the true leg stays driven high and the complement floats. With the bit set, both legs float. When the request is later released in the floating mode, the true leg is driven high again after a configurable number of clock cycles. Output restarts once the power-up sequencer raises its enable.

Top module: `clkpd_gate`

## Requirements
- R1: While `rstN` is low, and afterwards until a restart, the pins read `outTrue`=1, `oeTrue`=1, `outComp`=0, `oeComp`=0. Reset selects the hold-high parking mode.
- R2: While running, `outComp` equals `refClk`, `outTrue` equals its inverse, and both enables are 1.
- R3: A level on `pwrDnN` is acted on only after it has been sampled on two consecutive rising edges of `refClk`. A low seen at a single rising edge leaves the outputs toggling.
- R4: If `pwrDnN` goes low during a low phase of `refClk` and stays low, the high phases of `outComp` starting at the next SYNC_STAGES+2 rising edges are complete. The pair then stops at the falling edge that follows, and `outComp` stays low.
- R5: Stopped with parking mode 0, `outTrue`=1 with `oeTrue`=1, and `outComp`=0 with `oeComp`=0.
- R6: Stopped with parking mode 1, `oeTrue`=0 and `oeComp`=0.
- R7: The parking mode is the value of `driveMode` at the falling edge where the pair stops. Changes of `driveMode` while stopped have no effect on the enables.
- R8: Stopped in mode 1 with `restartEn` low, after the request is released (`pwrDnN` high for two samples), `oeTrue` rises with `outTrue`=1 exactly DRIVE_DELAY rising edges after the release is taken.
- R9: The pair restarts at the first falling edge where the request is released and `restartEn` is 1. Its first `outComp` high phase is a full one, and `restartEn` low also stops the pair at a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock; sampling and gating edges |
| rstN | input | 1 | Asynchronous active-low reset, parks the pair |
| pwrDnN | input | 1 | Asynchronous active-low power-down request pin |
| driveMode | input | 1 | Parking mode: 0 hold true high, 1 float both |
| restartEn | input | 1 | Enable from the power-up sequencer allowing output |
| outTrue | output | 1 | True leg level |
| oeTrue | output | 1 | True leg drive enable (0 = high impedance) |
| outComp | output | 1 | Complement leg level |
| oeComp | output | 1 | Complement leg drive enable (0 = high impedance) |

## Verification
The hardest state to reach is a release from the floating mode with the sequencer enable held off. Only there does the delayed drive-high of the true leg become visible, and it also needs the mode bit to have been flipped while parked. A directed sequence builds this up in order: a stop in mode 1, a mode flip while stopped, a release with `restartEn` low, and finally the restart. Around it, random hold lengths on the pin, including single-edge pulses, test the two-sample acceptance at every half cycle.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;

  // strobes from the control half to the output datapath
  typedef struct packed {
    logic run;        // pair toggles with the reference clock
    logic parkTri;    // captured parking mode: 1 floats the true leg
    logic driveHigh;  // delayed re-drive of the true leg after release
  } gateCtl_t;

endpackage

// File: rtl/clkpd_sync.sv
module clkpd_sync #(
  parameter int STAGES = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic pinN,
  output logic sampNew,
  output logic sampOld
);

  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] chain;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge refClk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= pinN;
        end
      end else begin : g_rest
        always_ff @(posedge refClk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign sampNew = chain[DEPTH-2];
  assign sampOld = chain[DEPTH-1];

endmodule

// File: rtl/clkpd_ctrl.sv
module clkpd_ctrl
  import clkpd_pkg::*;
#(
  parameter int DRIVE_DELAY = 8
) (
  input  logic     refClk,
  input  logic     rstN,
  input  logic     sampNew,
  input  logic     sampOld,
  input  logic     driveMode,
  input  logic     restartEn,
  output gateCtl_t ctl
);

  localparam int CNT_W = $clog2(DRIVE_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DRIVE_DELAY - 1);

  logic parkQ;
  logic runQ;
  logic modeHeld;
  logic driveHighQ;
  logic [CNT_W-1:0] relCnt;
  logic runNext;
  logic relQualify;

  // request state with two-sample agreement in both directions
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      parkQ <= 1'b1;
    end else if (!sampNew && !sampOld) begin
      parkQ <= 1'b1;
    end else if (sampNew && sampOld) begin
      parkQ <= 1'b0;
    end
  end

  assign runNext = !parkQ && restartEn;

  // gating decision lands on the falling edge only
  always_ff @(negedge refClk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      modeHeld <= 1'b0;
    end else begin
      runQ <= runNext;
      if (runQ && !runNext) modeHeld <= driveMode;
    end
  end

  // delayed re-drive of the true leg after release in floating mode
  assign relQualify = !parkQ && !runQ && modeHeld;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      relCnt     <= '0;
      driveHighQ <= 1'b0;
    end else if (!relQualify) begin
      relCnt     <= '0;
      driveHighQ <= 1'b0;
    end else if (!driveHighQ) begin
      relCnt <= relCnt + 1'b1;
      if (relCnt == CNT_LAST) driveHighQ <= 1'b1;
    end
  end

  assign ctl.run       = runQ;
  assign ctl.parkTri   = modeHeld;
  assign ctl.driveHigh = driveHighQ;

  // R3: entering the stopped request needs two agreeing low samples
  p_accept_two_low_r3: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(parkQ) |-> $past(!sampNew && !sampOld));

  // R3: leaving it needs two agreeing high samples
  p_release_two_high_r3: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(parkQ) |-> $past(sampNew && sampOld));

  // R4: an accepted request stops the pair by the next falling edge
  p_stop_after_accept_r4: assert property (@(negedge refClk) disable iff (!rstN)
    parkQ |=> !runQ);

  // R7: parking mode frozen while stopped
  p_mode_frozen_r7: assert property (@(posedge refClk) disable iff (!rstN)
    (!runQ && $past(!runQ)) |-> $stable(modeHeld));

endmodule

// File: rtl/clkpd_dpath.sv
module clkpd_dpath
  import clkpd_pkg::*;
(
  input  logic     refClk,
  input  logic     rstN,
  input  gateCtl_t ctl,
  output logic     outTrue,
  output logic     oeTrue,
  output logic     outComp,
  output logic     oeComp
);

  always_comb begin
    if (ctl.run) begin
      outComp = refClk;
      outTrue = !refClk;
      oeComp  = 1'b1;
      oeTrue  = 1'b1;
    end else begin
      outComp = 1'b0;
      outTrue = 1'b1;
      oeComp  = 1'b0;
      oeTrue  = !ctl.parkTri || ctl.driveHigh;
    end
  end

  // R2: running pair is complementary and driven (sampled in high phase)
  p_run_enabled_r2: assert property (@(negedge refClk) disable iff (!rstN)
    ctl.run |-> (outComp && !outTrue && oeTrue && oeComp));

  // R5: hold-high parking drives only the true leg, high
  p_park_hold_r5: assert property (@(posedge refClk) disable iff (!rstN)
    (!ctl.run && !ctl.parkTri) |-> (outTrue && oeTrue && !oeComp));

  // R6: floating parking releases both legs
  p_park_tri_r6: assert property (@(posedge refClk) disable iff (!rstN)
    (!ctl.run && ctl.parkTri && !ctl.driveHigh) |-> (!oeTrue && !oeComp));

endmodule

// File: rtl/clkpd_gate.sv
module clkpd_gate
  import clkpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DRIVE_DELAY = 8
) (
  input  logic refClk,
  input  logic rstN,
  input  logic pwrDnN,
  input  logic driveMode,
  input  logic restartEn,
  output logic outTrue,
  output logic oeTrue,
  output logic outComp,
  output logic oeComp
);

  logic     sampNew;
  logic     sampOld;
  gateCtl_t ctl;

  clkpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .refClk  (refClk),
    .rstN    (rstN),
    .pinN    (pwrDnN),
    .sampNew (sampNew),
    .sampOld (sampOld)
  );

  clkpd_ctrl #(.DRIVE_DELAY(DRIVE_DELAY)) u_ctrl (
    .refClk    (refClk),
    .rstN      (rstN),
    .sampNew   (sampNew),
    .sampOld   (sampOld),
    .driveMode (driveMode),
    .restartEn (restartEn),
    .ctl       (ctl)
  );

  clkpd_dpath u_dpath (
    .refClk  (refClk),
    .rstN    (rstN),
    .ctl     (ctl),
    .outTrue (outTrue),
    .oeTrue  (oeTrue),
    .outComp (outComp),
    .oeComp  (oeComp)
  );

endmodule

// File: tb/clkpd_gate_bench.sv
module clkpd_gate_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int SYNC_STAGES = 2;
  localparam int DRIVE_DELAY = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrDnN = 1'b0;
  logic driveMode = 1'b0;
  logic restartEn = 1'b0;
  logic outTrue, oeTrue, outComp, oeComp;

  int vecCnt = 0;
  int errCnt = 0;
  bit done = 1'b0;

  logic [3:0] hiSnap, loSnap;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkpd_gate #(.SYNC_STAGES(SYNC_STAGES), .DRIVE_DELAY(DRIVE_DELAY)) u_clkpd_gate (
    .refClk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .driveMode(driveMode),
    .restartEn(restartEn), .outTrue(outTrue), .oeTrue(oeTrue),
    .outComp(outComp), .oeComp(oeComp)
  );

  // behavioural expectation built from the requirements
  logic [SYNC_STAGES:0] mSamp;
  logic mStopped, mRun, mFloat, mDrive;
  int   mRelEdges;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSamp <= '0; mStopped <= 1'b1; mRelEdges <= 0; mDrive <= 1'b0;
    end else begin
      mSamp <= {mSamp[SYNC_STAGES-1:0], pwrDnN};
      if (mSamp[SYNC_STAGES] == mSamp[SYNC_STAGES-1])
        mStopped <= !mSamp[SYNC_STAGES];
      if (mStopped || mRun || !mFloat) begin
        mRelEdges <= 0; mDrive <= 1'b0;
      end else if (!mDrive) begin
        mRelEdges <= mRelEdges + 1;
        mDrive <= (mRelEdges + 1 >= DRIVE_DELAY);
      end
    end
  end

  always @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun <= 1'b0; mFloat <= 1'b0;
    end else begin
      mRun <= !mStopped && restartEn;
      if (mRun && !(!mStopped && restartEn)) mFloat <= driveMode;
    end
  end

  // {outTrue, oeTrue, outComp, oeComp}
  function automatic logic [3:0] expPins(input logic clkHi, input logic run,
                                         input logic flt, input logic drv);
    if (run) return {!clkHi, 1'b1, clkHi, 1'b1};
    return {1'b1, (!flt || drv), 1'b0, 1'b0};
  endfunction

  function automatic string stateTag(input logic run, input logic flt, input logic drv);
    if (run) return "R2";
    if (!flt) return "R5";
    if (drv) return "R8";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s at %0t: pins {true,oeT,comp,oeC} actual %b expected %b",
               tag, $time, act, exp);
    end
  endtask

  // one clock cycle with a model comparison in each phase
  task automatic cycle();
    @(posedge clk); #2;
    hiSnap = {outTrue, oeTrue, outComp, oeComp};
    check(stateTag(mRun, mFloat, mDrive), hiSnap, expPins(1'b1, mRun, mFloat, mDrive));
    @(negedge clk); #2;
    loSnap = {outTrue, oeTrue, outComp, oeComp};
    check(stateTag(mRun, mFloat, mDrive), loSnap, expPins(1'b0, mRun, mFloat, mDrive));
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errCnt++;
    $display("FAIL watchdog expired at %0t: actual hung, expected completion", $time);
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: parked during reset
    #7;
    check("R1", {outTrue, oeTrue, outComp, oeComp}, 4'b1100);
    #(CLK_PERIOD * 2);
    check("R1", {outTrue, oeTrue, outComp, oeComp}, 4'b1100);
    @(negedge clk); #3;
    rstN = 1'b1;
    // R1: stays parked with the sequencer enable low
    for (int k = 0; k < 3; k++) begin
      cycle();
      check("R1", hiSnap, 4'b1100);
    end

    // R9: release and start, mode 0
    pwrDnN = 1'b1; restartEn = 1'b1; driveMode = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      cycle();
      if (k == 4) check("R9", hiSnap, 4'b1100);
      if (k == 6) check("R9", hiSnap, 4'b0111);
    end

    // R3: low seen at one rising edge only
    pwrDnN = 1'b0;
    cycle();
    pwrDnN = 1'b1;
    for (int k = 0; k < 6; k++) begin
      cycle();
      check("R3", hiSnap, 4'b0111);
    end

    // R4 and R6: stop in floating mode, count complete high phases
    driveMode = 1'b1;
    pwrDnN = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      cycle();
      if (k <= SYNC_STAGES + 2) check("R4", hiSnap, 4'b0111);
      else begin
        check("R4", {1'b0, 1'b0, hiSnap[1], 1'b0}, 4'b0000);
        check("R6", {1'b0, hiSnap[2], 1'b0, hiSnap[0]}, 4'b0000);
      end
    end

    // R7: mode change while stopped is ignored
    driveMode = 1'b0;
    for (int k = 0; k < 3; k++) begin
      cycle();
      check("R7", {1'b0, hiSnap[2], 1'b0, loSnap[2]}, 4'b0000);
    end

    // R8: release with the sequencer enable held off
    restartEn = 1'b0; pwrDnN = 1'b1;
    for (int k = 1; k <= DRIVE_DELAY + 4; k++) begin
      cycle();
      if (k == DRIVE_DELAY + 3) check("R8", hiSnap, 4'b1000);
      if (k == DRIVE_DELAY + 4) check("R8", hiSnap, 4'b1100);
    end

    // R9: restart with a full first high phase
    restartEn = 1'b1;
    cycle();
    check("R9", hiSnap, 4'b1100);
    check("R9", loSnap, 4'b1101);
    cycle();
    check("R9", hiSnap, 4'b0111);

    // R9: enable low also stops at a falling edge
    restartEn = 1'b0;
    cycle();
    check("R9", hiSnap, 4'b0111);
    cycle();
    check("R9", {hiSnap[3], 1'b0, hiSnap[1], hiSnap[0]}, 4'b1000);
    restartEn = 1'b1;

    // random segments checked against the model
    for (int s = 0; s < 600; s++) begin
      int len;
      len = 1 + int'($urandom % 6);
      pwrDnN = (($urandom % 3) != 0);
      for (int c = 0; c < len; c++) begin
        driveMode = $urandom % 2;
        restartEn = (($urandom % 10) != 0);
        if (($urandom % 8) == 0) restartEn = 1'b0;
        cycle();
      end
    end

    finishRun();
  end

endmodule